// File: doc/BRIEF.md
# Dual-Clock Word FIFO with Selectable Read Timing

This block carries 36-bit words from a producer on one clock to a consumer on another clock. The two clocks run freely. They may be unrelated, or they may be one and the same clock. Storage is an inferred two-port array of `DEPTH` words. `DEPTH` is a power of two and defaults to 2048; 4096 and 8192 are also supported. Write and read pointers are kept in binary in their own domains. Each crosses to the other domain as Gray code through a two-stage synchroniser.

A static mode input sets how the read side behaves:
- **Standard timing.** The two status outputs are full and empty flags. A read strobe taken while not empty places the next word on the data output one read clock later.
- **Look-ahead timing.** The same outputs become input-ready and output-ready. The oldest stored word waits on the data output with output-ready high, and a strobe removes it.

Each side also has a threshold flag, almost-full on the write side and almost-empty on the read side. Their offsets can be reloaded through a per-domain load strobe and return to 8 on reset.

Top module: `xclk_fifo`

## Requirements
- R1: Words leave in the order they were written, all 36 bits intact, for a FIFO filled to its full capacity of `DEPTH` words.
- R2: In standard mode (`fwft_mode`=0), a read strobe sampled on a read-clock edge while `rd_empty_or` is low puts the oldest word on `rd_data` after that edge. `rd_empty_or` is high (empty) from the edge that removes the last visible word.
- R3: In standard mode, `wr_full_ir` (full) rises on the write edge that stores word number `DEPTH`. A write strobe while full changes nothing. Full falls within a few write clocks after reads free space.
- R4: A read strobe while empty in standard mode is ignored. Afterwards, the next written word is the next word read.
- R5: In look-ahead mode (`fwft_mode`=1), the first word written to an empty FIFO appears on `rd_data` with `rd_empty_or` (output-ready) high and no strobe. The word holds until a strobe, and each strobe advances to the next word or drops output-ready.
- R6: In look-ahead mode, `wr_full_ir` is input-ready. It is high whenever the write side is not full.
- R7: `wr_afull` is high when the free space seen by the write side is at or below the full offset. It is registered in the write domain and is high whenever full is high.
- R8: `rd_aempty` is high when the stored count seen by the read side is at or below the empty offset. It is registered in the read domain and is high whenever standard-mode empty is high.
- R9: A pulse on `wr_off_load` (write clock) or `rd_off_load` (read clock) replaces the corresponding offset. The new offset governs the flag from the next edge of that clock.
- R10: While reset is applied and after it is released, with no traffic, the status outputs show the following. Standard mode: empty high, almost-empty high, full low, almost-full low. Look-ahead mode: output-ready low and input-ready high. Both offsets are 8.
- R11: When both ports share one clock, a write and a read on the same edge both take effect, with data still in order.
- R12: Each pointer's Gray form changes by at most one bit per edge. After a write to an empty FIFO, the empty flag clears within 5 read clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| fwft_mode | input | 1 | Static timing select: 0 standard, 1 look-ahead |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 36 | Word to store |
| wr_off_load | input | 1 | Loads `wr_off_val` as the almost-full offset |
| wr_off_val | input | 12 | Almost-full offset value (AW+1 bits) |
| wr_full_ir | output | 1 | Full (standard) or input-ready (look-ahead) |
| wr_afull | output | 1 | Almost-full flag, write domain |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 36 | Word read, or head word in look-ahead mode |
| rd_off_load | input | 1 | Loads `rd_off_val` as the almost-empty offset |
| rd_off_val | input | 12 | Almost-empty offset value (AW+1 bits) |
| rd_empty_or | output | 1 | Empty (standard) or output-ready (look-ahead) |
| rd_aempty | output | 1 | Almost-empty flag, read domain |

## Verification
The bound checker enforces the following on every clock:
- A blocked write leaves the write pointer unchanged, and a blocked read leaves the read pointer unchanged.
- Both Gray pointers move by at most one bit per edge.
- The almost flags always cover the full and empty states.
- A head word in look-ahead mode stays put until it is consumed.

Only the directed scenarios can show data order across a complete fill, the exact edge on which full and the almost flags switch, and how quickly empty clears. They also cover offset reloads, the look-ahead first-word presentation, and simultaneous write and read on a shared clock.

// File: rtl/xf_pkg.sv
`timescale 1ns/1ps
package xf_pkg;

    // Static read-timing selection
    typedef enum logic {
        XF_STD  = 1'b0,
        XF_FWFT = 1'b1
    } xf_mode_e;

    localparam int XF_DATA_W_DEFAULT = 36;
    localparam int XF_OFF_DEFAULT    = 8;

endpackage

// File: rtl/xf_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser chain with asynchronous clear (STAGES >= 2)
module xf_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CW = W * STAGES;

    logic [CW-1:0] chain_q;
    logic [CW-1:0] chain_d;

    always_comb begin
        chain_d = {chain_q[CW-W-1:0], d};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q = chain_q[CW-1 -: W];
endmodule

// File: rtl/xf_wr_side.sv
`timescale 1ns/1ps
// Write-domain pointer, full and almost-full logic
module xf_wr_side #(
    parameter  int AW          = 11,
    parameter  int OFF_DEFAULT = 8,
    localparam int PW          = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          off_load,
    input  logic [PW-1:0] off_val,
    input  logic [PW-1:0] rgray_s,
    output logic          fire,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic [PW-1:0] wbin,
    output logic          full,
    output logic          afull
);
    localparam logic [PW-1:0] CAP = PW'(2 ** AW);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic [PW-1:0] off;
        logic          full;
        logic          afull;
    } wr_state_t;

    wr_state_t     st_q, st_d;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] used;
    logic [PW-1:0] room;

    always_comb begin
        // Gray to binary: each bit is the parity of itself and all higher bits
        for (int i = 0; i < PW; i++) begin
            rbin_s[i] = ^(rgray_s >> i);
        end
        fire        = wr_en && !st_q.full;
        st_d        = st_q;
        st_d.bin    = st_q.bin + PW'(fire);
        st_d.gray   = st_d.bin ^ (st_d.bin >> 1);
        if (off_load) begin
            st_d.off = off_val;
        end
        used        = st_d.bin - rbin_s;
        room        = CAP - used;
        st_d.full   = (used == CAP);
        st_d.afull  = (room <= st_d.off);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bin   <= '0;
            st_q.gray  <= '0;
            st_q.off   <= PW'(OFF_DEFAULT);
            st_q.full  <= 1'b0;
            st_q.afull <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign waddr = st_q.bin[AW-1:0];
    assign wgray = st_q.gray;
    assign wbin  = st_q.bin;
    assign full  = st_q.full;
    assign afull = st_q.afull;
endmodule

// File: rtl/xf_rd_side.sv
`timescale 1ns/1ps
// Read-domain pointer, empty / output-ready and almost-empty logic
module xf_rd_side #(
    parameter  int AW          = 11,
    parameter  int OFF_DEFAULT = 8,
    localparam int PW          = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwft_mode,
    input  logic          rd_en,
    input  logic          off_load,
    input  logic [PW-1:0] off_val,
    input  logic [PW-1:0] wgray_s,
    output logic          fetch,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic [PW-1:0] rbin,
    output logic          empty,
    output logic          ovalid,
    output logic          aempty
);
    import xf_pkg::*;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic [PW-1:0] off;
        logic          empty;
        logic          ovalid;
        logic          aempty;
    } rd_state_t;

    rd_state_t     st_q, st_d;
    xf_mode_e      mode;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] stored;
    logic          avail;

    always_comb begin
        mode = xf_mode_e'(fwft_mode);
        for (int i = 0; i < PW; i++) begin
            wbin_s[i] = ^(wgray_s >> i);
        end
        avail = (st_q.bin != wbin_s);
        st_d  = st_q;
        if (mode == XF_FWFT) begin
            // Refill the head register whenever it is free or being consumed
            fetch = avail && (!st_q.ovalid || rd_en);
            if (fetch) begin
                st_d.ovalid = 1'b1;
            end else if (rd_en) begin
                st_d.ovalid = 1'b0;
            end
        end else begin
            fetch       = rd_en && !st_q.empty;
            st_d.ovalid = 1'b0;
        end
        st_d.bin  = st_q.bin + PW'(fetch);
        st_d.gray = st_d.bin ^ (st_d.bin >> 1);
        if (off_load) begin
            st_d.off = off_val;
        end
        stored      = wbin_s - st_d.bin + PW'(st_d.ovalid);
        st_d.empty  = (wbin_s == st_d.bin);
        st_d.aempty = (stored <= st_d.off);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bin    <= '0;
            st_q.gray   <= '0;
            st_q.off    <= PW'(OFF_DEFAULT);
            st_q.empty  <= 1'b1;
            st_q.ovalid <= 1'b0;
            st_q.aempty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr  = st_q.bin[AW-1:0];
    assign rgray  = st_q.gray;
    assign rbin   = st_q.bin;
    assign empty  = st_q.empty;
    assign ovalid = st_q.ovalid;
    assign aempty = st_q.aempty;
endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
// Dual-clock FIFO, one direction, with standard or look-ahead read timing
module xclk_fifo #(
    parameter  int DATA_W      = xf_pkg::XF_DATA_W_DEFAULT,
    parameter  int DEPTH       = 2048,
    parameter  int OFF_DEFAULT = xf_pkg::XF_OFF_DEFAULT,
    localparam int AW          = $clog2(DEPTH),
    localparam int PW          = AW + 1
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              arst_n,
    input  logic              fwft_mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_off_load,
    input  logic [PW-1:0]     wr_off_val,
    output logic              wr_full_ir,
    output logic              wr_afull,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rd_off_load,
    input  logic [PW-1:0]     rd_off_val,
    output logic              rd_empty_or,
    output logic              rd_aempty
);
    logic              wrst_n, rrst_n;
    logic              w_fire, r_fetch;
    logic [AW-1:0]     w_addr, r_addr;
    logic [PW-1:0]     w_gray, w_bin, r_gray, r_bin;
    logic [PW-1:0]     w_gray_s, r_gray_s;
    logic              w_full, w_afull;
    logic              r_empty, r_ovalid, r_aempty;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    // Per-domain reset release
    xf_sync #(.W(1), .STAGES(2)) u_wrst (
        .clk(wr_clk), .arst_n(arst_n), .d(1'b1), .q(wrst_n)
    );
    xf_sync #(.W(1), .STAGES(2)) u_rrst (
        .clk(rd_clk), .arst_n(arst_n), .d(1'b1), .q(rrst_n)
    );

    // Gray pointer crossings
    xf_sync #(.W(PW), .STAGES(2)) u_w2r (
        .clk(rd_clk), .arst_n(rrst_n), .d(w_gray), .q(w_gray_s)
    );
    xf_sync #(.W(PW), .STAGES(2)) u_r2w (
        .clk(wr_clk), .arst_n(wrst_n), .d(r_gray), .q(r_gray_s)
    );

    xf_wr_side #(.AW(AW), .OFF_DEFAULT(OFF_DEFAULT)) u_wr (
        .clk(wr_clk), .rst_n(wrst_n), .wr_en(wr_en),
        .off_load(wr_off_load), .off_val(wr_off_val), .rgray_s(r_gray_s),
        .fire(w_fire), .waddr(w_addr), .wgray(w_gray), .wbin(w_bin),
        .full(w_full), .afull(w_afull)
    );

    xf_rd_side #(.AW(AW), .OFF_DEFAULT(OFF_DEFAULT)) u_rd (
        .clk(rd_clk), .rst_n(rrst_n), .fwft_mode(fwft_mode), .rd_en(rd_en),
        .off_load(rd_off_load), .off_val(rd_off_val), .wgray_s(w_gray_s),
        .fetch(r_fetch), .raddr(r_addr), .rgray(r_gray), .rbin(r_bin),
        .empty(r_empty), .ovalid(r_ovalid), .aempty(r_aempty)
    );

    // Storage array: write port on wr_clk, registered read port on rd_clk
    always_ff @(posedge wr_clk) begin
        if (w_fire) begin
            mem[w_addr] <= wr_data;
        end
    end

    always_ff @(posedge rd_clk or negedge rrst_n) begin
        if (!rrst_n) begin
            rdata_q <= '0;
        end else if (r_fetch) begin
            rdata_q <= mem[r_addr];
        end
    end

    assign rd_data     = rdata_q;
    assign wr_full_ir  = fwft_mode ? !w_full : w_full;
    assign wr_afull    = w_afull;
    assign rd_empty_or = fwft_mode ? r_ovalid : r_empty;
    assign rd_aempty   = r_aempty;
endmodule

// File: rtl/xclk_fifo_chk.sv
`timescale 1ns/1ps
// Property checker attached to xclk_fifo
module xclk_fifo_chk #(
    parameter int AW     = 11,
    parameter int DATA_W = 36
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              wrst_n,
    input logic              rrst_n,
    input logic              fwft_mode,
    input logic              wr_en,
    input logic              rd_en,
    input logic              w_full,
    input logic              w_afull,
    input logic              r_empty,
    input logic              r_ovalid,
    input logic              r_aempty,
    input logic [AW:0]       w_bin,
    input logic [AW:0]       r_bin,
    input logic [AW:0]       w_gray,
    input logic [AW:0]       r_gray,
    input logic [DATA_W-1:0] rd_data
);
    AST_FULL_BLOCKS_WRITE: assert property (@(posedge wr_clk) disable iff (!wrst_n)
        (w_full && wr_en) |=> $stable(w_bin)); // R3

    AST_EMPTY_BLOCKS_READ: assert property (@(posedge rd_clk) disable iff (!rrst_n)
        (!fwft_mode && r_empty && rd_en) |=> $stable(r_bin)); // R4

    AST_WGRAY_ONE_STEP: assert property (@(posedge wr_clk) disable iff (!wrst_n)
        $countones(w_gray ^ $past(w_gray)) <= 1); // R12

    AST_RGRAY_ONE_STEP: assert property (@(posedge rd_clk) disable iff (!rrst_n)
        $countones(r_gray ^ $past(r_gray)) <= 1); // R12

    AST_FULL_HAS_AFULL: assert property (@(posedge wr_clk) disable iff (!wrst_n)
        w_full |-> w_afull); // R7

    AST_EMPTY_HAS_AEMPTY: assert property (@(posedge rd_clk) disable iff (!rrst_n)
        (!fwft_mode && r_empty) |-> r_aempty); // R8

    AST_HEAD_HOLDS: assert property (@(posedge rd_clk) disable iff (!rrst_n)
        (fwft_mode && r_ovalid && !rd_en) |=> (r_ovalid && $stable(rd_data))); // R5
endmodule

bind xclk_fifo xclk_fifo_chk #(.AW(AW), .DATA_W(DATA_W)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .wrst_n(wrst_n), .rrst_n(rrst_n),
    .fwft_mode(fwft_mode), .wr_en(wr_en), .rd_en(rd_en),
    .w_full(w_full), .w_afull(w_afull), .r_empty(r_empty),
    .r_ovalid(r_ovalid), .r_aempty(r_aempty), .w_bin(w_bin), .r_bin(r_bin),
    .w_gray(w_gray), .r_gray(r_gray), .rd_data(rd_data)
);

// File: tb/test_xclk_fifo.sv
`timescale 1ns/1ps
module test_xclk_fifo;
    localparam int DW    = 36;
    localparam int DEPTH = 2048;
    localparam int PW    = 12;

    logic          wclk = 1'b0;
    logic          aclk = 1'b0;
    logic          rclk;
    logic          use_same = 1'b0;
    logic          arst_n = 1'b0;
    logic          fwft = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic          wol = 1'b0;
    logic          rol = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [PW-1:0] wov = '0;
    logic [PW-1:0] rov = '0;
    logic [DW-1:0] rdata;
    logic          full_ir, afull, empty_or, aempty;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 wclk = ~wclk;
    always #3.5 aclk = ~aclk;
    assign rclk = use_same ? wclk : aclk;

    xclk_fifo i_xclk_fifo (
        .wr_clk(wclk), .rd_clk(rclk), .arst_n(arst_n), .fwft_mode(fwft),
        .wr_en(wr_en), .wr_data(wdata), .wr_off_load(wol), .wr_off_val(wov),
        .wr_full_ir(full_ir), .wr_afull(afull),
        .rd_en(rd_en), .rd_data(rdata), .rd_off_load(rol), .rd_off_val(rov),
        .rd_empty_or(empty_or), .rd_aempty(aempty)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reset_dut(input logic mode, input logic same);
        @(negedge wclk);
        arst_n   = 1'b0;
        wr_en    = 1'b0;
        rd_en    = 1'b0;
        wol      = 1'b0;
        rol      = 1'b0;
        fwft     = mode;
        use_same = same;
        repeat (3) @(negedge wclk);
        arst_n = 1'b1;
        repeat (4) @(negedge wclk);
        repeat (4) @(negedge rclk);
    endtask

    task automatic wr1(input logic [DW-1:0] v);
        @(negedge wclk);
        wr_en = 1'b1;
        wdata = v;
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    task automatic rd1(output logic [DW-1:0] v);
        @(negedge rclk);
        rd_en = 1'b1;
        @(negedge rclk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic wait_r(input int n);
        repeat (n) @(negedge rclk);
    endtask

    task automatic t_reset_state();
        reset_dut(1'b0, 1'b0);
        check("R10 std empty", empty_or, 1);
        check("R10 std full", full_ir, 0);
        check("R10 std aempty", aempty, 1);
        check("R10 std afull", afull, 0);
    endtask

    task automatic t_basic();
        logic [DW-1:0] v;
        int lat;
        reset_dut(1'b0, 1'b0);
        wr1(36'hA_1234_5678);
        lat = 0;
        for (int k = 0; k < 8 && empty_or; k++) begin
            @(negedge rclk);
            lat++;
        end
        check("R12 empty clear latency<=5", (lat <= 5), 1);
        wr1(36'h5_DEAD_BEEF);
        wr1(36'hF_0000_0001);
        wait_r(6);
        rd1(v); check("R2 word0", v, 36'hA_1234_5678);
        rd1(v); check("R2 word1", v, 36'h5_DEAD_BEEF);
        rd1(v); check("R1 word2 all bits", v, 36'hF_0000_0001);
        check("R2 empty after last read", empty_or, 1);
    endtask

    task automatic t_read_empty();
        logic [DW-1:0] v;
        reset_dut(1'b0, 1'b0);
        repeat (3) rd1(v);
        check("R4 still empty", empty_or, 1);
        wr1(36'h3_3333_3333);
        wait_r(6);
        rd1(v);
        check("R4 next word after ignored reads", v, 36'h3_3333_3333);
        check("R4 empty again", empty_or, 1);
    endtask

    task automatic t_fill();
        logic [DW-1:0] v;
        int errs;
        reset_dut(1'b0, 1'b0);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge wclk);
            if (i == DEPTH - 9) check("R7 afull low at free 9", afull, 0);
            if (i == DEPTH - 8) check("R7 afull high at free 8", afull, 1);
            wr_en = 1'b1;
            wdata = DW'(i);
        end
        @(negedge wclk);
        check("R3 full after last write", full_ir, 1);
        wr_en = 1'b1;
        wdata = 36'hE_EEEE_EEEE;
        @(negedge wclk);
        wr_en = 1'b0;
        check("R3 full held on extra write", full_ir, 1);
        wait_r(6);
        errs = 0;
        for (int i = 0; i < DEPTH; i++) begin
            rd1(v);
            if (v !== DW'(i)) errs++;
        end
        check("R1 order over full depth", errs, 0);
        check("R3 extra write dropped", empty_or, 1);
        repeat (6) @(negedge wclk);
        check("R3 full released", full_ir, 0);
    endtask

    task automatic t_almost_empty();
        logic [DW-1:0] v;
        reset_dut(1'b0, 1'b0);
        for (int i = 0; i < 9; i++) wr1(DW'(i));
        wait_r(8);
        check("R8 aempty low at count 9", aempty, 0);
        rd1(v);
        check("R8 aempty high at count 8", aempty, 1);
        @(negedge rclk);
        rol = 1'b1;
        rov = PW'(2);
        @(negedge rclk);
        rol = 1'b0;
        check("R9 aempty low with offset 2", aempty, 0);
        repeat (5) rd1(v);
        check("R9 aempty low at count 3", aempty, 0);
        rd1(v);
        check("R9 aempty high at count 2", aempty, 1);
        repeat (2) rd1(v);
    endtask

    task automatic t_wr_offset();
        reset_dut(1'b0, 1'b0);
        @(negedge wclk);
        wol = 1'b1;
        wov = PW'(DEPTH - 2);
        @(negedge wclk);
        wol = 1'b0;
        check("R9 afull low at free 2048", afull, 0);
        wr1(36'h1);
        check("R9 afull low at free 2047", afull, 0);
        wr1(36'h2);
        check("R9 afull high at free 2046", afull, 1);
    endtask

    task automatic t_fwft();
        reset_dut(1'b1, 1'b0);
        check("R10 fwft output-ready low", empty_or, 0);
        check("R6 input-ready high", full_ir, 1);
        wr1(36'hC_0000_0000);
        for (int k = 0; k < 8 && !empty_or; k++) @(negedge rclk);
        check("R5 output-ready without read", empty_or, 1);
        check("R5 head word shown", rdata, 36'hC_0000_0000);
        wr1(36'hC_0000_0001);
        wr1(36'hC_0000_0002);
        wait_r(6);
        check("R5 head held without strobe", rdata, 36'hC_0000_0000);
        check("R6 input-ready with data stored", full_ir, 1);
        @(negedge rclk); rd_en = 1'b1;
        @(negedge rclk); rd_en = 1'b0;
        check("R5 advance to word1", rdata, 36'hC_0000_0001);
        check("R5 ready after advance", empty_or, 1);
        @(negedge rclk); rd_en = 1'b1;
        @(negedge rclk); rd_en = 1'b0;
        check("R5 advance to word2", rdata, 36'hC_0000_0002);
        @(negedge rclk); rd_en = 1'b1;
        @(negedge rclk); rd_en = 1'b0;
        check("R5 ready drops when drained", empty_or, 0);
    endtask

    task automatic t_same_clock();
        logic [DW-1:0] v;
        int errs;
        reset_dut(1'b0, 1'b1);
        for (int i = 0; i < 4; i++) wr1(DW'(100 + i));
        repeat (6) @(negedge wclk);
        errs = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge wclk);
            if (i > 0 && rdata !== DW'(100 + i - 1)) errs++;
            wr_en = 1'b1;
            wdata = DW'(104 + i);
            rd_en = 1'b1;
        end
        @(negedge wclk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        if (rdata !== DW'(105)) errs++;
        check("R11 simultaneous reads in order", errs, 0);
        repeat (6) @(negedge wclk);
        errs = 0;
        for (int i = 0; i < 4; i++) begin
            rd1(v);
            if (v !== DW'(106 + i)) errs++;
        end
        check("R11 simultaneous writes kept", errs, 0);
        check("R11 empty after drain", empty_or, 1);
    endtask

    initial begin
        t_reset_state();
        t_basic();
        t_read_empty();
        t_almost_empty();
        t_wr_offset();
        t_fill();
        t_fwft();
        t_same_clock();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge wclk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule